// File: doc/BRIEF.md
# Edge Boundary Mask Generator

This block turns two byte addresses into a partial-store mask for an 8-byte word. It is meant for span loops over packed pixels, where the first and last words of a span are only partly covered. The first address marks where the span begins and gives the left mask. The second address marks where the span ends and gives the right mask. When both addresses lie in the same aligned 8-byte word, only the elements covered by both masks are enabled.

Elements can be 8, 16 or 32 bits wide, and lane order can be big-endian or little-endian. Some opcodes also report integer condition flags from subtracting the second address from the first. These flags come at both 32-bit and 64-bit width, so a loop can branch on the remaining distance without a separate compare.

A start strobe registers the result. One cycle later the block presents it with a single-cycle done pulse. A flag-write enable marks the results whose flags the consumer should commit.

Top module: `edge_mask_unit`

## Requirements
- R1: While reset is asserted and right after it, `mask_o`, `icc_o` and `xcc_o` are zero, and `done_o` and `flag_we_o` are low.
- R2: The opcode is decoded by field. `opc_i[3:2]` picks the element size: 0 for 8-bit, 1 for 16-bit, 2 for 32-bit, and 3 is handled as 8-bit. `opc_i[1]` selects little-endian lane order. `opc_i[0]`, when set, suppresses the flag update.
- R3: For 8-bit elements the index is address bits [2:0]. In big-endian order, the left mask is 0xFF shifted right by the index, and the right mask has its top index+1 bits set. In little-endian order, the left mask is 0xFF shifted left by the index and truncated to 8 bits, and the right mask has its low index+1 bits set.
- R4: For 16-bit elements the index is address bits [2:1] and the mask has 4 lanes, built by the same four rules over 4 bits. Big-endian left masks are F,7,3,1 and right masks are 8,C,E,F. Little-endian left masks are F,E,C,8 and right masks are 1,3,7,F.
- R5: For 32-bit elements the index is address bit 2 and the mask has 2 lanes. Big-endian left masks are 3,1 and right masks are 2,3. Little-endian left masks are 3,2 and right masks are 1,3. Masks narrower than 8 bits are zero-extended in `mask_o`.
- R6: The left mask is taken from `addr_a_i` and the right mask from `addr_b_i`. `mask_o` is their AND when the two addresses match with bits [2:0] cleared, and the left mask alone otherwise.
- R7: With `mode32_i` set, bits [63:32] of both addresses are ignored in the same-word comparison. With it clear, those bits take part.
- R8: `icc_o` and `xcc_o` hold {N,Z,V,C} (N in bit 3, C in bit 0) for `addr_a_i - addr_b_i`. `icc_o` uses the low 32 bits and `xcc_o` all 64 bits, always on the full original addresses whatever `mode32_i` is. C is the borrow, set when a < b unsigned.
- R9: `flag_we_o` pulses together with `done_o` only when `opc_i[0]` was 0. When `opc_i[0]` was 1, `icc_o` and `xcc_o` keep their previous values.
- R10: `done_o` is high for exactly the one cycle after a cycle with `start_i` high. `mask_o` and the flags are updated at that edge and hold while `start_i` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Registers a new operation |
| opc_i | input | 4 | Size, lane order and flag-suppress fields |
| addr_a_i | input | 64 | Span start address (left mask) |
| addr_b_i | input | 64 | Span end address (right mask) |
| mode32_i | input | 1 | Compare only the low 32 address bits |
| mask_o | output | 8 | Registered lane mask, zero-extended |
| icc_o | output | 4 | {N,Z,V,C} of the 32-bit subtraction |
| xcc_o | output | 4 | {N,Z,V,C} of the 64-bit subtraction |
| flag_we_o | output | 1 | Flags of this result are to be committed |
| done_o | output | 1 | Result valid, one cycle after start |

## Verification
Random operations cover all twelve opcodes and four address relations. Pairs in the same word show whether the AND is applied. Pairs that differ only above bit 31 separate the effect of the 32-bit mode. Fully random pairs and pairs a few bytes apart exercise the left-only path and the carry and sign flags. Directed cases pin the table values for each size and lane order, equal addresses (zero flag), a signed overflow at 32 bits, and a flag-suppressed operation that must leave earlier flags intact.

// File: rtl/edge_mask_pkg.sv
package edge_mask_pkg;

   typedef enum logic [1:0] {
      ESZ_8   = 2'd0,
      ESZ_16  = 2'd1,
      ESZ_32  = 2'd2,
      ESZ_RSV = 2'd3
   } elem_size_e;

   typedef struct packed {
      logic n;
      logic z;
      logic v;
      logic c;
   } cc_flags_t;

   // Reserved size code falls back to byte elements.
   function automatic int unsigned size_sel(input logic [1:0] code);
      elem_size_e e;
      e = elem_size_e'(code);
      case (e)
         ESZ_16:  return 1;
         ESZ_32:  return 2;
         default: return 0;
      endcase
   endfunction

endpackage

// File: rtl/edge_lane_masks.sv
module edge_lane_masks #(
   parameter int LANES = 8,
   localparam int IDX_W = (LANES > 1) ? $clog2(LANES) : 1
) (
   input  logic [IDX_W-1:0] idx_a,
   input  logic [IDX_W-1:0] idx_b,
   output logic [LANES-1:0] left_be,
   output logic [LANES-1:0] right_be,
   output logic [LANES-1:0] left_le,
   output logic [LANES-1:0] right_le
);

   generate
      if (LANES < 2 || (1 << IDX_W) != LANES) begin : g_bad_lanes
         $error("edge_lane_masks: LANES must be a power of two >= 2");
      end
   endgenerate

   // Lane j counts from bit 0. Big-endian puts element 0 at the MSB.
   always_comb begin
      for (int j = 0; j < LANES; j++) begin
         left_be[j]  = (j <= LANES - 1 - int'(idx_a));
         right_be[j] = (j >= LANES - 1 - int'(idx_b));
         left_le[j]  = (j >= int'(idx_a));
         right_le[j] = (j <= int'(idx_b));
      end
   end

   // R3, R4, R5: the outer lane of each mask is always enabled, and the
   // two left masks cover the same number of lanes.
   always_comb begin
      a_r3_edge_anchor: assert (left_be[0] && right_be[LANES-1] &&
                                left_le[LANES-1] && right_le[0]);
      a_r4_left_count: assert ($countones(left_be) == $countones(left_le));
   end

endmodule

// File: rtl/edge_sub_flags.sv
module edge_sub_flags
   import edge_mask_pkg::*;
#(
   parameter int W = 64
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   output cc_flags_t    flags
);

   generate
      if (W < 2) begin : g_bad_w
         $error("edge_sub_flags: W must be at least 2");
      end
   endgenerate

   logic [W:0] diff;

   always_comb begin
      diff    = {1'b0, a} - {1'b0, b};
      flags.n = diff[W-1];
      flags.z = (diff[W-1:0] == '0);
      flags.v = (a[W-1] ^ b[W-1]) & (a[W-1] ^ diff[W-1]);
      flags.c = diff[W];
   end

endmodule

// File: rtl/edge_mask_unit.sv
module edge_mask_unit
   import edge_mask_pkg::*;
#(
   parameter int ADDR_W     = 64,
   parameter int NARROW_W   = 32,
   parameter int WORD_BYTES = 8
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        start_i,
   input  logic [3:0]  opc_i,
   input  logic [63:0] addr_a_i,
   input  logic [63:0] addr_b_i,
   input  logic        mode32_i,
   output logic [7:0]  mask_o,
   output logic [3:0]  icc_o,
   output logic [3:0]  xcc_o,
   output logic        flag_we_o,
   output logic        done_o
);

   localparam int OFS_W   = $clog2(WORD_BYTES);
   localparam int N_SIZES = 3;

   generate
      if (ADDR_W != 64) begin : g_bad_addr
         $error("edge_mask_unit: ADDR_W must match the 64-bit address ports");
      end
      if (NARROW_W >= ADDR_W || NARROW_W <= OFS_W) begin : g_bad_narrow
         $error("edge_mask_unit: NARROW_W must lie between the offset and ADDR_W");
      end
      if (WORD_BYTES != 8) begin : g_bad_word
         $error("edge_mask_unit: WORD_BYTES must be 8 for three element sizes");
      end
   endgenerate

   // Per-size masks, zero-extended to the word width.
   logic [WORD_BYTES-1:0] lbe [N_SIZES];
   logic [WORD_BYTES-1:0] rbe [N_SIZES];
   logic [WORD_BYTES-1:0] lle [N_SIZES];
   logic [WORD_BYTES-1:0] rle [N_SIZES];

   generate
      for (genvar s = 0; s < N_SIZES; s++) begin : g_size
         localparam int LANES = WORD_BYTES >> s;
         localparam int IW    = OFS_W - s;
         logic [LANES-1:0] l_be, r_be, l_le, r_le;

         edge_lane_masks #(.LANES(LANES)) u_lanes (
            .idx_a    (addr_a_i[OFS_W-1 -: IW]),
            .idx_b    (addr_b_i[OFS_W-1 -: IW]),
            .left_be  (l_be),
            .right_be (r_be),
            .left_le  (l_le),
            .right_le (r_le)
         );

         assign lbe[s] = WORD_BYTES'(l_be);
         assign rbe[s] = WORD_BYTES'(r_be);
         assign lle[s] = WORD_BYTES'(l_le);
         assign rle[s] = WORD_BYTES'(r_le);
      end
   endgenerate

   // Opcode decode and selection
   logic                  little_end;
   logic                  no_flags;
   int unsigned           sz;
   logic [WORD_BYTES-1:0] left_sel, right_sel, mask_nxt;
   logic                  same_word;

   always_comb begin
      little_end = opc_i[1];
      no_flags   = opc_i[0];
      sz         = size_sel(opc_i[3:2]);
      left_sel   = little_end ? lle[sz] : lbe[sz];
      right_sel  = little_end ? rle[sz] : rbe[sz];
      if (mode32_i)
         same_word = (addr_a_i[NARROW_W-1:OFS_W] == addr_b_i[NARROW_W-1:OFS_W]);
      else
         same_word = (addr_a_i[ADDR_W-1:OFS_W] == addr_b_i[ADDR_W-1:OFS_W]);
      mask_nxt   = same_word ? (left_sel & right_sel) : left_sel;
   end

   // Subtraction flags on the full original addresses
   cc_flags_t icc_nxt, xcc_nxt;

   edge_sub_flags #(.W(NARROW_W)) u_icc (
      .a     (addr_a_i[NARROW_W-1:0]),
      .b     (addr_b_i[NARROW_W-1:0]),
      .flags (icc_nxt)
   );

   edge_sub_flags #(.W(ADDR_W)) u_xcc (
      .a     (addr_a_i),
      .b     (addr_b_i),
      .flags (xcc_nxt)
   );

   // Result registers
   logic [WORD_BYTES-1:0] mask_q;
   cc_flags_t             icc_q, xcc_q;
   logic                  we_q, done_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_q <= '0;
         icc_q  <= '0;
         xcc_q  <= '0;
         we_q   <= 1'b0;
         done_q <= 1'b0;
      end else begin
         done_q <= start_i;
         we_q   <= start_i & ~no_flags;
         if (start_i) begin
            mask_q <= mask_nxt;
            if (!no_flags) begin
               icc_q <= icc_nxt;
               xcc_q <= xcc_nxt;
            end
         end
      end
   end

   assign mask_o    = mask_q;
   assign icc_o     = icc_q;
   assign xcc_o     = xcc_q;
   assign flag_we_o = we_q;
   assign done_o    = done_q;

   // R10: done follows start by exactly one cycle
   a_r10_done_after_start: assert property (@(posedge clk) disable iff (!rst_n)
      start_i |=> done_o);
   a_r10_done_needs_start: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> $past(start_i));
   // R10: the mask holds while no operation is started
   a_r10_mask_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !done_o |-> $stable(mask_o));
   // R9: the flag-write enable only comes with done
   a_r9_we_with_done: assert property (@(posedge clk) disable iff (!rst_n)
      flag_we_o |-> done_o);
   // R9: a suppressed operation leaves both flag sets unchanged
   a_r9_suppressed_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && !flag_we_o) |-> ($stable(icc_o) && $stable(xcc_o)));

endmodule

// File: tb/edge_mask_unit_test.sv
`timescale 1ns/1ps
module edge_mask_unit_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0;
   logic [3:0]  opc_i = '0;
   logic [63:0] addr_a_i = '0;
   logic [63:0] addr_b_i = '0;
   logic        mode32_i = 1'b0;
   logic [7:0]  mask_o;
   logic [3:0]  icc_o, xcc_o;
   logic        flag_we_o, done_o;

   int n_cmp = 0;
   int n_bad = 0;
   logic [3:0] exp_icc = '0;
   logic [3:0] exp_xcc = '0;

   always #2 clk = ~clk;

   edge_mask_unit uut (
      .clk, .rst_n, .start_i, .opc_i, .addr_a_i, .addr_b_i, .mode32_i,
      .mask_o, .icc_o, .xcc_o, .flag_we_o, .done_o
   );

   task automatic report();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   initial begin
      #(200000 * 4);
      n_bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      report();
   end

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   // Model of the lane masks from the shift rules (R3, R4, R5)
   function automatic logic [7:0] exp_mask(input logic [3:0] opc, input logic [63:0] a,
                                           input logic [63:0] b, input logic m32);
      int s, lanes, all, ia, ib, l, r;
      bit same;
      s = (opc[3:2] == 2'd3) ? 0 : int'(opc[3:2]);
      lanes = 8 >> s;
      all = (1 << lanes) - 1;
      ia = int'(a[2:0]) >> s;
      ib = int'(b[2:0]) >> s;
      if (!opc[1]) begin
         l = all >> ia;
         r = all & ~(all >> (ib + 1));
      end else begin
         l = (all << ia) & all;
         r = (1 << (ib + 1)) - 1;
      end
      same = m32 ? (a[31:3] == b[31:3]) : (a[63:3] == b[63:3]);
      return 8'(same ? (l & r) : l);
   endfunction

   // {N,Z,V,C} model from comparisons (R8)
   function automatic logic [3:0] flags32(input logic [31:0] a, input logic [31:0] b);
      logic [31:0] d;
      logic n, lt;
      d = a - b;
      n = d[31];
      lt = ($signed(a) < $signed(b));
      return {n, d == 0, lt ^ n, a < b};
   endfunction

   function automatic logic [3:0] flags64(input logic [63:0] a, input logic [63:0] b);
      logic [63:0] d;
      logic n, lt;
      d = a - b;
      n = d[63];
      lt = ($signed(a) < $signed(b));
      return {n, d == 0, lt ^ n, a < b};
   endfunction

   task automatic run_op(input logic [3:0] opc, input logic [63:0] a,
                         input logic [63:0] b, input logic m32, input string tag);
      logic [7:0] em;
      em = exp_mask(opc, a, b, m32);
      if (!opc[0]) begin
         exp_icc = flags32(a[31:0], b[31:0]);
         exp_xcc = flags64(a, b);
      end
      @(negedge clk);
      opc_i = opc; addr_a_i = a; addr_b_i = b; mode32_i = m32; start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      check({tag, " mask"}, 64'(mask_o), 64'(em));
      check("R8 icc", 64'(icc_o), 64'(exp_icc));
      check("R8 xcc", 64'(xcc_o), 64'(exp_xcc));
      check("R9 flag_we", 64'(flag_we_o), 64'(!opc[0]));
      check("R10 done", 64'(done_o), 64'd1);
   endtask

   initial begin
      logic [63:0] a, b, hold;
      int unsigned seed;
      seed = 32'd7;
      void'($urandom(seed));
      // R1 reset state
      #5;
      check("R1 mask", 64'(mask_o), 64'd0);
      check("R1 icc", 64'(icc_o), 64'd0);
      check("R1 xcc", 64'(xcc_o), 64'd0);
      check("R1 done", 64'(done_o), 64'd0);
      check("R1 we", 64'(flag_we_o), 64'd0);
      @(negedge clk); rst_n = 1'b1;
      @(negedge clk);
      check("R1 mask after", 64'(mask_o), 64'd0);

      // Directed corner cases
      run_op(4'h0, 64'h0, 64'h7, 1'b0, "R3 be full");          // FF
      run_op(4'h0, 64'h3, 64'h5, 1'b0, "R3 be same");          // 1C
      run_op(4'h2, 64'h3, 64'h5, 1'b0, "R3 le same");          // 38
      run_op(4'h4, 64'h2, 64'h10, 1'b0, "R4 be left only");    // 7
      run_op(4'h6, 64'h6, 64'h6, 1'b0, "R4 le same");          // 8
      run_op(4'h8, 64'h4, 64'h4, 1'b0, "R5 be same");          // 1
      run_op(4'hA, 64'h4, 64'h4, 1'b0, "R5 le same");          // 2
      run_op(4'hC, 64'h5, 64'h5, 1'b0, "R2 reserved size");    // 8-bit
      run_op(4'h0, 64'h1_0000_0000, 64'h0, 1'b1, "R7 narrow same");  // 80
      run_op(4'h0, 64'h1_0000_0000, 64'h0, 1'b0, "R7 wide differ");  // FF
      run_op(4'h0, 64'h0, 64'h1, 1'b0, "R8 borrow");
      run_op(4'h0, 64'h8000_0000, 64'h1, 1'b0, "R8 overflow32");
      run_op(4'h2, 64'h40, 64'h40, 1'b0, "R8 zero");
      // R9: suppressed op keeps the zero flags from the previous one
      run_op(4'h1, 64'h0, 64'h9, 1'b0, "R9 suppressed");
      run_op(4'h6, 64'h2, 64'h38, 1'b0, "R6 different words");

      // R10: outputs hold and done drops when start stays low
      hold = 64'(mask_o);
      @(negedge clk);
      check("R10 done low", 64'(done_o), 64'd0);
      check("R10 mask hold", 64'(mask_o), hold);
      check("R9 we low", 64'(flag_we_o), 64'd0);

      // Constrained random mix (R2, R3, R4, R5, R6, R7, R8)
      for (int i = 0; i < 400; i++) begin
         a = {$urandom, $urandom};
         case ($urandom % 4)
            0: b = a ^ 64'($urandom % 8);
            1: b = {$urandom, a[31:3], 3'($urandom)};
            2: b = {$urandom, $urandom};
            default: b = a + 64'($urandom % 24);
         endcase
         run_op(4'($urandom % 12), a, b, 1'($urandom), "R6 random");
      end
      report();
   end

endmodule